// File: doc/BRIEF.md
# Serial Channel Host Register Front End

This block is the byte-wide register window a host processor uses to run one asynchronous serial channel. The host presents a 3-bit address, an 8-bit write bus and single-cycle read and write strobes. The block keeps the channel's line format, the baud divisor, the interrupt enables and the FIFO mode bit, and drives them out as configuration signals. It also gathers the channel's status and turns it into one prioritized interrupt request, which the host can identify.

The serializer, the deserializer and their FIFOs sit outside. The block tells the transmit side to take a byte with a one-cycle push pulse, and tells the receive side that its head byte has been consumed with a one-cycle pop pulse. The receive side reports whether a byte is waiting and presents it. The transmit side reports when its holding stage is empty. It also sends single-cycle pulses for line errors and for an auxiliary status event. Eight addresses carry all the registers: a divisor-latch bit in the format register swaps the divisor bytes in at addresses 0 and 1, and address 2 has different meanings for reads and writes.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, rdata is 0x00, irq is 0, the format register reads 0x03 (8-bit characters, 1 stop bit, no parity), baud_div is 0x0001, fifo_en is 0, and the identification register at address 2 reads 0x01.
- R2: The format register at address 3 can be read and written. Bits [1:0] give char_len (00=5 bits up to 11=8 bits). Bit 2 selects extra stop time, and stop_cfg is then 01 (1.5 bits) for 5-bit characters and 10 (2 bits) otherwise. With bit 2 clear, stop_cfg is 00 (1 bit). Bit 3 enables parity and bit 4 selects even parity, giving par_mode 00=none, 01=odd, 10=even. Bit 7 is the divisor-latch bit.
- R3: While the divisor-latch bit is set, addresses 0 and 1 read and write the low and high bytes of baud_div. Such accesses cause neither tx_push nor rx_pop.
- R4: While the divisor-latch bit is clear, a write to address 0 gives tx_push=1 with tx_data equal to the written byte in the next cycle. A read of address 0 returns rx_data in rdata in the next cycle and pulses rx_pop in that same cycle.
- R5: Address 5 reads {2'b00, tx_hold_empty, break, framing, parity, overrun, rx_avail}. The four error bits are sticky and are set by line_err[3:0] (bit 0 overrun, 1 parity, 2 framing, 3 break). A read returns the value before the clear and then clears them. An error that arrives in the same cycle as the read stays set.
- R6: Address 2 reads {fifo_en, fifo_en, 2'b00, id}. The id is 0110 for a line error, 0100 for received data, 0010 for transmitter empty, 0000 for an auxiliary event and 0001 for nothing pending, and the highest pending enabled source wins in that order.
- R7: The transmitter-empty source becomes pending when tx_hold_empty rises, or when its enable bit is written from 0 to 1 while tx_hold_empty is 1. It is cleared by a read of address 2 that reports it, or by a transmit data write.
- R8: The interrupt-enable register at address 1 (latch bit clear) uses bits [3:0]: 0 receive, 1 transmitter empty, 2 line error, 3 auxiliary. irq is registered: it is 1 in the cycle after any enabled source is pending, and it stays 0 while all enables are 0.
- R9: Writing address 2 sets fifo_en from bit 0 of the byte.
- R10: Address 6 reads {7'b0, aux}. aux is sticky: aux_evt sets it, and a read of address 6 clears it after returning it.
- R11: Address 7 is a byte that can be read and written and has no other effect. Address 4 reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Host register address |
| wdata | input | 8 | Host write data |
| rd | input | 1 | Read strobe, one access per cycle |
| wr | input | 1 | Write strobe, one access per cycle |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |
| tx_push | output | 1 | Transmit byte valid pulse |
| tx_data | output | 8 | Byte for the transmit side |
| tx_hold_empty | input | 1 | Transmit holding stage empty |
| rx_avail | input | 1 | Receive byte waiting |
| rx_data | input | 8 | Head byte of the receive side |
| rx_pop | output | 1 | Receive byte consumed pulse |
| line_err | input | 4 | Error pulses: overrun, parity, framing, break |
| aux_evt | input | 1 | Auxiliary status event pulse |
| char_len | output | 2 | Character length code |
| par_mode | output | 2 | Parity mode |
| stop_cfg | output | 2 | Stop time code |
| fifo_en | output | 1 | FIFO mode select |
| baud_div | output | 16 | Baud divisor |

## Verification
The assertions check the following on every cycle. Every push or pop pulse traces back to a data-address access made with the latch bit clear. The divisor moves only under a write, and a latched low-byte write lands in the divisor. A status read with no new error leaves the error bits clear, and cleared enables keep irq low. The priority order, the clearing of the transmitter-empty source by an identification read, the set-wins rule for errors, and the 1.5-stop case for 5-bit characters depend on sequences of accesses. Only the bench's directed scenarios and its reference model, compared every cycle under mixed random traffic, can show these.

// File: rtl/uart_hreg_pkg.sv
package uart_hreg_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int NSRC   = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 3'd0,
    A_IEN   = 3'd1,
    A_IDENT = 3'd2,
    A_FMT   = 3'd3,
    A_RSV   = 3'd4,
    A_LSTAT = 3'd5,
    A_AUX   = 3'd6,
    A_SCR   = 3'd7
  } reg_addr_e;

  localparam logic [3:0] ID_LINE = 4'b0110;
  localparam logic [3:0] ID_RX   = 4'b0100;
  localparam logic [3:0] ID_TX   = 4'b0010;
  localparam logic [3:0] ID_AUX  = 4'b0000;
  localparam logic [3:0] ID_NONE = 4'b0001;
endpackage

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_hreg_pkg::*;
#(
  parameter logic [DATA_W-1:0]   FMT_RESET = 8'h03,
  parameter logic [2*DATA_W-1:0] DIV_RESET = 16'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] fmt,
  output logic [NSRC-1:0]   ien,
  output logic [2*DATA_W-1:0] div,
  output logic              fifo_en,
  output logic [DATA_W-1:0] scratch,
  output logic              dlab,
  output logic              ien_tx_rise
);
  assign dlab        = fmt[7];
  assign ien_tx_rise = wr && (addr == A_IEN) && !dlab && wdata[1] && !ien[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt     <= FMT_RESET;
      ien     <= '0;
      div     <= DIV_RESET;
      fifo_en <= 1'b0;
      scratch <= '0;
    end else if (wr) begin
      case (addr)
        A_DATA:  if (dlab) div[DATA_W-1:0] <= wdata;
        A_IEN:   if (dlab) div[2*DATA_W-1:DATA_W] <= wdata;
                 else      ien <= wdata[NSRC-1:0];
        A_IDENT: fifo_en <= wdata[0];
        A_FMT:   fmt <= wdata;
        A_SCR:   scratch <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_status_track.sv
module uart_status_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_lstat,
  input  logic       rd_aux,
  input  logic [3:0] line_err,
  input  logic       aux_evt,
  input  logic       tx_hold_empty,
  input  logic       tx_write,
  input  logic       ien_tx_rise,
  input  logic       tx_ack,
  output logic [3:0] err_q,
  output logic       aux_q,
  output logic       thre_q
);
  logic empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= '0;
      aux_q   <= 1'b0;
      thre_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      err_q   <= (rd_lstat ? 4'b0 : err_q) | line_err;
      aux_q   <= (rd_aux & ~aux_evt) ? 1'b0 : (aux_q | aux_evt);
      empty_q <= tx_hold_empty;
      if ((tx_hold_empty && !empty_q) || (ien_tx_rise && tx_hold_empty))
        thre_q <= 1'b1;
      else if (tx_write || tx_ack)
        thre_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_hreg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ien,
  input  logic            err_any,
  input  logic            rx_avail,
  input  logic            thre,
  input  logic            aux,
  output logic [3:0]      id,
  output logic            irq
);
  logic [NSRC-1:0] pend;
  assign pend = ien & {aux, err_any, thre, rx_avail};

  always_comb begin
    if (pend[2])      id = ID_LINE;
    else if (pend[0]) id = ID_RX;
    else if (pend[1]) id = ID_TX;
    else if (pend[3]) id = ID_AUX;
    else              id = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend;
  end
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_hreg_pkg::*;
#(
  parameter logic [DATA_W-1:0]   FMT_RESET = 8'h03,
  parameter logic [2*DATA_W-1:0] DIV_RESET = 16'h0001
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                rd,
  input  logic                wr,
  output logic [DATA_W-1:0]   rdata,
  output logic                irq,
  output logic                tx_push,
  output logic [DATA_W-1:0]   tx_data,
  input  logic                tx_hold_empty,
  input  logic                rx_avail,
  input  logic [DATA_W-1:0]   rx_data,
  output logic                rx_pop,
  input  logic [3:0]          line_err,
  input  logic                aux_evt,
  output logic [1:0]          char_len,
  output logic [1:0]          par_mode,
  output logic [1:0]          stop_cfg,
  output logic                fifo_en,
  output logic [2*DATA_W-1:0] baud_div
);
  logic [DATA_W-1:0] fmt, scratch, rd_mux;
  logic [NSRC-1:0]   ien;
  logic              dlab, ien_tx_rise;
  logic [3:0]        err_q, id;
  logic              aux_q, thre_q;
  logic              data_wr, data_rd, id_rd;

  assign data_wr = wr && (addr == A_DATA) && !dlab;
  assign data_rd = rd && (addr == A_DATA) && !dlab;
  assign id_rd   = rd && (addr == A_IDENT) && (id == ID_TX);

  uart_cfg_regs #(.FMT_RESET(FMT_RESET), .DIV_RESET(DIV_RESET)) u_cfg (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wdata(wdata),
    .fmt(fmt), .ien(ien), .div(baud_div), .fifo_en(fifo_en),
    .scratch(scratch), .dlab(dlab), .ien_tx_rise(ien_tx_rise)
  );

  uart_status_track u_stat (
    .clk(clk), .rst(rst),
    .rd_lstat(rd && (addr == A_LSTAT)), .rd_aux(rd && (addr == A_AUX)),
    .line_err(line_err), .aux_evt(aux_evt), .tx_hold_empty(tx_hold_empty),
    .tx_write(data_wr), .ien_tx_rise(ien_tx_rise), .tx_ack(id_rd),
    .err_q(err_q), .aux_q(aux_q), .thre_q(thre_q)
  );

  uart_irq_prio u_prio (
    .clk(clk), .rst(rst), .ien(ien), .err_any(|err_q), .rx_avail(rx_avail),
    .thre(thre_q), .aux(aux_q), .id(id), .irq(irq)
  );

  assign char_len = fmt[1:0];
  assign par_mode = !fmt[3] ? 2'b00 : (fmt[4] ? 2'b10 : 2'b01);
  assign stop_cfg = !fmt[2] ? 2'b00 : ((fmt[1:0] == 2'b00) ? 2'b01 : 2'b10);

  always_comb begin
    case (addr)
      A_DATA:  rd_mux = dlab ? baud_div[DATA_W-1:0] : rx_data;
      A_IEN:   rd_mux = dlab ? baud_div[2*DATA_W-1:DATA_W] : {{(DATA_W-NSRC){1'b0}}, ien};
      A_IDENT: rd_mux = {fifo_en, fifo_en, 2'b00, id};
      A_FMT:   rd_mux = fmt;
      A_LSTAT: rd_mux = {2'b00, tx_hold_empty, err_q, rx_avail};
      A_AUX:   rd_mux = {7'b0, aux_q};
      A_SCR:   rd_mux = scratch;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      tx_push <= 1'b0;
      tx_data <= '0;
      rx_pop  <= 1'b0;
    end else begin
      if (rd) rdata <= rd_mux;
      tx_push <= data_wr;
      rx_pop  <= data_rd;
      if (data_wr) tx_data <= wdata;
    end
  end
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        rd,
  input logic        wr,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic        dlab,
  input logic        tx_push,
  input logic        rx_pop,
  input logic [15:0] baud_div,
  input logic        irq,
  input logic [3:0]  ien,
  input logic [3:0]  err_q,
  input logic [3:0]  line_err
);
  p_push_src_r4: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(wr && addr == 3'd0 && !dlab));
  p_pop_src_r4: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(rd && addr == 3'd0 && !dlab));
  p_div_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(wr) |-> $stable(baud_div));
  p_div_low_r3: assert property (@(posedge clk) disable iff (rst)
    $past(wr && dlab && addr == 3'd0) |-> baud_div[7:0] == $past(wdata));
  p_err_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rd && addr == 3'd5 && line_err == 4'd0) |-> err_q == 4'd0);
  p_mask_r8: assert property (@(posedge clk) disable iff (rst)
    $past(ien) == 4'd0 |-> !irq);
endmodule

bind uart_host_regs uart_host_regs_chk u_chk (
  .clk(clk), .rst(rst), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
  .dlab(dlab), .tx_push(tx_push), .rx_pop(rx_pop), .baud_div(baud_div),
  .irq(irq), .ien(ien), .err_q(err_q), .line_err(line_err)
);

// File: tb/uart_host_regs_tb.sv
module uart_host_regs_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rx_data = '0;
  logic rd = 1'b0, wr = 1'b0, tx_hold_empty = 1'b1, rx_avail = 1'b0, aux_evt = 1'b0;
  logic [3:0] line_err = '0;
  logic [7:0] rdata, tx_data;
  logic irq, tx_push, rx_pop, fifo_en;
  logic [1:0] char_len, par_mode, stop_cfg;
  logic [15:0] baud_div;
  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_host_regs u_dut (.*);

  // behavioural reference model
  logic [7:0] m_fmt, m_scr, m_rdata, m_txd;
  logic [3:0] m_ien, m_err;
  logic [15:0] m_div;
  logic m_fifo, m_aux, m_thre, m_prev, m_irq, m_push, m_pop;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_fmt = 8'h03; m_scr = 0; m_rdata = 0; m_txd = 0; m_ien = 0; m_err = 0;
      m_div = 16'h0001; m_fifo = 0; m_aux = 0; m_thre = 0; m_prev = 1;
      m_irq = 0; m_push = 0; m_pop = 0;
    end else begin
      automatic bit dl = m_fmt[7];
      automatic bit pl = m_ien[2] && (m_err != 0);
      automatic bit pr = m_ien[0] && rx_avail;
      automatic bit pt = m_ien[1] && m_thre;
      automatic bit pa = m_ien[3] && m_aux;
      automatic logic [3:0] id = pl ? 4'h6 : pr ? 4'h4 : pt ? 4'h2 : pa ? 4'h0 : 4'h1;
      automatic bit wthr = wr && addr == 0 && !dl;
      automatic bit set_t = (tx_hold_empty && !m_prev) ||
                            (wr && addr == 1 && !dl && wdata[1] && !m_ien[1] && tx_hold_empty);
      automatic bit clr_t = wthr || (rd && addr == 2 && id == 4'h2);
      if (rd) begin
        case (addr)
          0: m_rdata = dl ? m_div[7:0] : rx_data;
          1: m_rdata = dl ? m_div[15:8] : {4'b0, m_ien};
          2: m_rdata = {m_fifo, m_fifo, 2'b00, id};
          3: m_rdata = m_fmt;
          5: m_rdata = {2'b00, tx_hold_empty, m_err, rx_avail};
          6: m_rdata = {7'b0, m_aux};
          7: m_rdata = m_scr;
          default: m_rdata = 0;
        endcase
      end
      m_irq  = pl || pr || pt || pa;
      m_push = wthr;
      m_pop  = rd && addr == 0 && !dl;
      if (wthr) m_txd = wdata;
      m_err = ((rd && addr == 5) ? 4'b0 : m_err) | line_err;
      m_aux = ((rd && addr == 6) ? 1'b0 : m_aux) | aux_evt;
      if (set_t) m_thre = 1; else if (clr_t) m_thre = 0;
      m_prev = tx_hold_empty;
      if (wr) begin
        case (addr)
          0: if (dl) m_div[7:0] = wdata;
          1: if (dl) m_div[15:8] = wdata; else m_ien = wdata[3:0];
          2: m_fifo = wdata[0];
          3: m_fmt = wdata;
          7: m_scr = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (time %0t)", tag, got, exp, $time);
    end
  endtask

  function automatic string rtag(input logic [2:0] a);
    case (a)
      0, 1: return "R3/R4 rdata";
      2: return "R6 rdata";
      3: return "R2 rdata";
      5: return "R5 rdata";
      6: return "R10 rdata";
      default: return "R11 rdata";
    endcase
  endfunction

  logic [2:0] last_ra = 0;
  always @(posedge clk) if (rd) last_ra <= addr;

  always @(negedge clk) begin
    if (!rst && !done) begin
      automatic logic [1:0] pm = !m_fmt[3] ? 2'b00 : (m_fmt[4] ? 2'b10 : 2'b01);
      automatic logic [1:0] sc = !m_fmt[2] ? 2'b00 : (m_fmt[1:0] == 0 ? 2'b01 : 2'b10);
      chk(rdata, m_rdata, rtag(last_ra));
      chk(irq, m_irq, "R8 irq");
      chk(tx_push, m_push, "R4 tx_push");
      if (m_push) chk(tx_data, m_txd, "R4 tx_data");
      chk(rx_pop, m_pop, "R4 rx_pop");
      chk(char_len, m_fmt[1:0], "R2 char_len");
      chk(par_mode, pm, "R2 par_mode");
      chk(stop_cfg, sc, "R2 stop_cfg");
      chk(fifo_en, m_fifo, "R9 fifo_en");
      chk(baud_div, m_div, "R3 baud_div");
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1; @(negedge clk); wr = 0;
  endtask
  task automatic do_rd(input logic [2:0] a);
    addr = a; rd = 1; @(negedge clk); rd = 0;
  endtask

  initial begin
    step(3); rst = 0; step(1);
    chk(rdata, 8'h00, "R1 rdata"); chk(irq, 0, "R1 irq");
    chk(baud_div, 16'h0001, "R1 baud_div"); chk(fifo_en, 0, "R1 fifo_en");
    do_rd(2); chk(rdata, 8'h01, "R1 ident");
    do_rd(3); chk(rdata, 8'h03, "R1 format");
    // R2 format encodings
    do_wr(3, 8'h1C);
    chk(char_len, 2'b00, "R2 len5"); chk(stop_cfg, 2'b01, "R2 stop1.5"); chk(par_mode, 2'b10, "R2 even");
    do_wr(3, 8'h0F);
    chk(char_len, 2'b11, "R2 len8"); chk(stop_cfg, 2'b10, "R2 stop2"); chk(par_mode, 2'b01, "R2 odd");
    // R3 divisor overlay
    do_wr(3, 8'h83); do_wr(0, 8'h34); chk(tx_push, 0, "R3 no push");
    do_wr(1, 8'h12); chk(baud_div, 16'h1234, "R3 divisor");
    do_rd(0); chk(rdata, 8'h34, "R3 low"); chk(rx_pop, 0, "R3 no pop");
    do_rd(1); chk(rdata, 8'h12, "R3 high");
    do_wr(3, 8'h03);
    // R4 data path
    do_wr(0, 8'hA5); chk(tx_push, 1, "R4 push"); chk(tx_data, 8'hA5, "R4 data");
    rx_data = 8'h5A; rx_avail = 1;
    do_rd(0); chk(rdata, 8'h5A, "R4 rx"); chk(rx_pop, 1, "R4 pop");
    rx_avail = 0;
    // R5 line status
    line_err = 4'b0101; step(1); line_err = 0;
    do_rd(5); chk(rdata, 8'h2A, "R5 sticky");
    do_rd(5); chk(rdata, 8'h20, "R5 cleared");
    // R6/R7/R8/R10 priority chain
    do_wr(1, 8'h0F);
    rx_avail = 1; line_err = 4'b0010; aux_evt = 1; step(1); line_err = 0; aux_evt = 0;
    step(1); chk(irq, 1, "R8 irq");
    do_rd(2); chk(rdata, 8'h06, "R6 line first");
    do_rd(5); chk(rdata, 8'h25, "R5 parity");
    do_rd(2); chk(rdata, 8'h04, "R6 rx next");
    rx_avail = 0;
    do_rd(2); chk(rdata, 8'h02, "R6 tx next");
    do_rd(2); chk(rdata, 8'h00, "R7 tx cleared by ident read");
    do_rd(6); chk(rdata, 8'h01, "R10 aux");
    do_rd(2); chk(rdata, 8'h01, "R10 aux cleared");
    // R7 clear by transmit write
    tx_hold_empty = 0; step(1); tx_hold_empty = 1; step(2);
    chk(irq, 1, "R7 empty rise");
    do_wr(0, 8'h11); step(1); chk(irq, 0, "R7 cleared by write");
    // R8 masking
    do_wr(1, 8'h00); aux_evt = 1; step(1); aux_evt = 0; step(3);
    chk(irq, 0, "R8 masked");
    do_rd(6); chk(rdata, 8'h01, "R10 masked aux held");
    // R9 FIFO mode
    do_wr(2, 8'h01); chk(fifo_en, 1, "R9 fifo");
    do_rd(2); chk(rdata, 8'hC1, "R9 ident bits");
    // R11 scratch and reserved
    do_wr(7, 8'h3C); do_rd(7); chk(rdata, 8'h3C, "R11 scratch");
    do_wr(4, 8'hFF); do_rd(4); chk(rdata, 8'h00, "R11 reserved");
    do_rd(7); chk(rdata, 8'h3C, "R11 scratch kept");
    // mixed random traffic, model compared every clock
    for (int i = 0; i < 3000; i++) begin
      automatic int r = $urandom % 8;
      addr = 3'($urandom); wdata = 8'($urandom); rx_data = 8'($urandom);
      rd = (r < 3); wr = (r == 3 || r == 4);
      if (wr && addr == 3) wdata[7] = ($urandom % 4 == 0);
      rx_avail = ($urandom % 3 == 0);
      tx_hold_empty = ($urandom % 4 != 0);
      line_err = ($urandom % 8 == 0) ? 4'($urandom) : 4'b0;
      aux_evt = ($urandom % 10 == 0);
      step(1);
    end
    rd = 0; wr = 0; step(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule